// File: doc/BRIEF.md
# Lockable Four-Way Write-Through Data Cache

This block is a small data cache placed between a 32-bit processor request port and a slower word-wide memory port. It keeps 1 KB of data as 16 sets of four ways. Each line is four 32-bit words. Within a set, a read miss refills the least recently used way. If the set has an empty way, that way is used instead. Every store is written through to memory. A one-word posted buffer holds the store, so the processor is released in the same cycle while the memory write finishes in the background.

A freeze input stops the contents from changing. While it is high, hits are still served. Read misses fetch only the requested word and allocate nothing, and hits leave the recency order as it was. A disable input turns the cache into a pass-through: reads go to memory one word at a time and the arrays are left alone. A one-cycle invalidate pulse clears every valid bit at once. Stores are whole 32-bit words.

A single state machine owns the memory port. Its states are ST_IDLE, ST_DRAIN, ST_FILL and ST_FETCH, with these transitions:
- ST_IDLE to ST_DRAIN when the buffer holds a store.
- ST_IDLE to ST_FILL on a read miss when the buffer is empty, the cache is enabled and it is not frozen.
- ST_IDLE to ST_FETCH on a read miss when the buffer is empty and the cache is frozen or disabled.
- ST_DRAIN to ST_IDLE on the write acknowledge.
- ST_FILL to ST_IDLE on the acknowledge of the fourth word.
- ST_FETCH to ST_IDLE on the read acknowledge.

Hits are served in ST_IDLE and ST_DRAIN. Stores are accepted only in ST_IDLE with the buffer empty.

Top module: `wt_lock_dcache`

## Requirements
- R1: After reset no line is valid, `cpu_ready` and `mem_req` are low, and the first read of any address misses.
- R2: A read hit raises `cpu_ready` in the cycle the request is presented, with the cached word on `cpu_rdata` and no memory access.
- R3: A read miss, while the cache is enabled and not frozen, issues four memory reads of the line in ascending word order, ending with byte offset 12. It then returns the requested word, and every word of that line hits afterwards.
- R4: A refill uses an empty way of the set if there is one, otherwise the least recently used way. Every hit and every refill makes its way the most recent.
- R5: A store with the buffer empty completes in the cycle it is presented, and the buffer later writes it to memory. A store that finds the buffer full waits until the buffer drains. Memory receives the stores in program order.
- R6: A store hit also updates the cached word, so a later read hits and returns the new value.
- R7: A store miss allocates no line. A later read of that address misses and returns the stored value.
- R8: No memory read is issued while the buffer holds a store, so a read that follows a store to the same address returns the stored data.
- R9: While `freeze` is high, hits are served (a store hit also updates the cached word), read misses fetch only the requested word and allocate nothing, and hits do not change the recency order. The freeze level is sampled when a miss starts; a refill already under way completes.
- R10: While `cache_en` is low, every read fetches one word from memory and stores go through the buffer. The arrays and the recency order are untouched, so a line cached earlier keeps its old word.
- R11: A one-cycle `inv_all` pulse clears every valid bit, so every address misses afterwards.
- R12: Once `mem_req` is raised, it stays high, with `mem_addr` and `mem_we` stable, until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | High enables caching; low gives pass-through |
| freeze | input | 1 | High stops allocation and recency updates |
| inv_all | input | 1 | Pulse that clears all valid bits |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | High for a store |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | High for a memory write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory completion |

## Verification
The block has four latencies, one for each kind of result:
- A read hit, and a store that finds the buffer empty, complete in the cycle the request is presented.
- A frozen or disabled miss completes in the cycle of its single memory acknowledge.
- A refill takes four memory handshakes and then completes as a hit in the next cycle.
- A buffered store reaches memory only after its own handshake.

The bench drives inputs on the falling edge and samples 2 ns later. It counts the falling edges until `cpu_ready` and expects zero for the cases that must not wait. It judges hit or miss from the number of memory reads the responder counted, never from design internals. Memory-side results are checked only after an idle gap longer than one write handshake.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FILL,
        ST_FETCH
    } mem_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inv_all,
    input  logic [$clog2(SETS)-1:0] lk_set,
    input  logic [TAG_W-1:0]        lk_tag,
    output logic [WAYS-1:0]         hit_vec,
    output logic [WAYS-1:0]         valid_row,
    input  logic                    wr_en,
    input  logic [$clog2(SETS)-1:0] wr_set,
    input  logic [$clog2(WAYS)-1:0] wr_way,
    input  logic [TAG_W-1:0]        wr_tag
);
    logic [TAG_W-1:0] tags  [SETS][WAYS];
    logic [WAYS-1:0]  valid [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid[s] <= '0;
        end else if (inv_all) begin
            for (int s = 0; s < SETS; s++) valid[s] <= '0;
        end else if (wr_en) begin
            valid[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_set][wr_way] <= wr_tag;
    end

    assign valid_row = valid[lk_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[lk_set][w] && (tags[lk_set][w] == lk_tag);
    end

    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    parameter int LINE_WORDS = 4,
    parameter int DATA_W     = 32
) (
    input  logic                          clk,
    input  logic [$clog2(SETS)-1:0]       rd_set,
    input  logic [$clog2(WAYS)-1:0]       rd_way,
    input  logic [$clog2(LINE_WORDS)-1:0] rd_word,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          wr_en,
    input  logic [$clog2(SETS)-1:0]       wr_set,
    input  logic [$clog2(WAYS)-1:0]       wr_way,
    input  logic [$clog2(LINE_WORDS)-1:0] wr_word,
    input  logic [DATA_W-1:0]             wr_data
);
    localparam int IDX_W = $clog2(SETS) + $clog2(WAYS) + $clog2(LINE_WORDS);
    localparam int DEPTH = SETS * WAYS * LINE_WORDS;

    logic [DATA_W-1:0] words [DEPTH];
    logic [IDX_W-1:0]  rd_idx, wr_idx;

    assign rd_idx  = {rd_set, rd_way, rd_word};
    assign wr_idx  = {wr_set, wr_way, wr_word};
    assign rd_data = words[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_idx] <= wr_data;
    end
endmodule

// File: rtl/wtc_lru.sv
module wtc_lru #(
    parameter int WAYS = 4,
    parameter int SETS = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch_en,
    input  logic [$clog2(SETS)-1:0] touch_set,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    input  logic [$clog2(SETS)-1:0] q_set,
    output logic [$clog2(WAYS)-1:0] lru_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] age [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age[touch_set][w] <= '0;
                else if (age[touch_set][w] < age[touch_set][touch_way])
                    age[touch_set][w] <= age[touch_set][w] + WAY_W'(1);
            end
        end
    end

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age[q_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end

    for (genvar s = 0; s < SETS; s++) begin : g_perm
        logic [WAYS-1:0] seen;
        always_comb begin
            seen = '0;
            for (int w = 0; w < WAYS; w++) seen[age[s][w]] = 1'b1;
        end
        // R4
        lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (&seen));
    end
endmodule

// File: rtl/wt_lock_dcache.sv
module wt_lock_dcache
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 16,
    parameter int LINE_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              freeze,
    input  logic              inv_all,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int SET_W  = $clog2(SETS);
    localparam int WRD_W  = $clog2(LINE_WORDS);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - SET_W - WRD_W - BYTE_W;

    mem_state_e state_q, state_d;

    logic [SET_W-1:0]  a_set;
    logic [WRD_W-1:0]  a_word;
    logic [TAG_W-1:0]  a_tag;
    logic [WAYS-1:0]   hit_vec, valid_row;
    logic              hit_any;
    logic [WAY_W-1:0]  hit_way, lru_way, victim;
    logic [WAY_W-1:0]  fill_way_q;
    logic [WRD_W-1:0]  fill_cnt_q;
    logic              wb_valid_q;
    logic [ADDR_W-1:0] wb_addr_q;
    logic [DATA_W-1:0] wb_data_q;
    logic              serve_ok, rd_hit_done, st_take, fetch_done, fill_ack, fill_last, rd_miss;
    logic              dwr_en, touch_en;
    logic [WAY_W-1:0]  dwr_way, touch_way;
    logic [WRD_W-1:0]  dwr_word;
    logic [DATA_W-1:0] dwr_data, arr_rdata;

    assign a_word = cpu_addr[BYTE_W +: WRD_W];
    assign a_set  = cpu_addr[BYTE_W + WRD_W +: SET_W];
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    wtc_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_set(a_set), .lk_tag(a_tag), .hit_vec(hit_vec), .valid_row(valid_row),
        .wr_en(fill_last), .wr_set(a_set), .wr_way(fill_way_q), .wr_tag(a_tag)
    );

    wtc_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_set(a_set), .rd_way(hit_way), .rd_word(a_word), .rd_data(arr_rdata),
        .wr_en(dwr_en), .wr_set(a_set), .wr_way(dwr_way), .wr_word(dwr_word), .wr_data(dwr_data)
    );

    wtc_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_set(a_set), .touch_way(touch_way),
        .q_set(a_set), .lru_way(lru_way)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = lru_way;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_row[w]) begin
                victim = WAY_W'(w);
                found  = 1'b1;
            end
        end
    end

    assign hit_any     = cache_en && (|hit_vec);
    assign serve_ok    = (state_q == ST_IDLE) || (state_q == ST_DRAIN);
    assign rd_hit_done = serve_ok && cpu_req && !cpu_we && hit_any;
    assign st_take     = (state_q == ST_IDLE) && cpu_req && cpu_we && !wb_valid_q;
    assign fetch_done  = (state_q == ST_FETCH) && mem_ack;
    assign fill_ack    = (state_q == ST_FILL) && mem_ack;
    assign fill_last   = fill_ack && (fill_cnt_q == WRD_W'(LINE_WORDS - 1));
    assign rd_miss     = cpu_req && !cpu_we && !hit_any;

    assign dwr_en    = fill_ack || (st_take && hit_any);
    assign dwr_way   = (state_q == ST_FILL) ? fill_way_q : hit_way;
    assign dwr_word  = (state_q == ST_FILL) ? fill_cnt_q : a_word;
    assign dwr_data  = (state_q == ST_FILL) ? mem_rdata  : cpu_wdata;

    assign touch_en  = fill_last || ((rd_hit_done || (st_take && hit_any)) && !freeze);
    assign touch_way = fill_last ? fill_way_q : hit_way;

    assign cpu_ready = rd_hit_done || st_take || fetch_done;
    assign cpu_rdata = fetch_done ? mem_rdata : arr_rdata;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wb_valid_q)
                    state_d = ST_DRAIN;
                else if (rd_miss)
                    state_d = (cache_en && !freeze) ? ST_FILL : ST_FETCH;
            end
            ST_DRAIN: if (mem_ack)   state_d = ST_IDLE;
            ST_FILL:  if (fill_last) state_d = ST_IDLE;
            ST_FETCH: if (mem_ack)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_way_q <= '0;
            fill_cnt_q <= '0;
        end else if (state_q == ST_IDLE && state_d == ST_FILL) begin
            fill_way_q <= victim;
            fill_cnt_q <= '0;
        end else if (fill_ack) begin
            fill_cnt_q <= fill_cnt_q + WRD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_valid_q <= 1'b0;
            wb_addr_q  <= '0;
            wb_data_q  <= '0;
        end else if (st_take) begin
            wb_valid_q <= 1'b1;
            wb_addr_q  <= cpu_addr;
            wb_data_q  <= cpu_wdata;
        end else if (state_q == ST_DRAIN && mem_ack) begin
            wb_valid_q <= 1'b0;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = wb_addr_q;
        mem_wdata = wb_data_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRAIN: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {a_tag, a_set, fill_cnt_q, BYTE_W'(0)};
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cpu_addr;
            end
            default: ;
        endcase
    end

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    rd_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !wb_valid_q);

    // R5
    store_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |=> (wb_valid_q && wb_addr_q == $past(cpu_addr)));

    // R9
    frozen_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && freeze) |=> (state_q != ST_FILL));
endmodule

// File: tb/test_wt_lock_dcache.sv
module test_wt_lock_dcache;
    localparam int MEM_LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n, cache_en, freeze, inv_all;
    logic        cpu_req, cpu_we, cpu_ready;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int n_chk = 0, n_bad = 0;
    int rd_count = 0, wr_count = 0, proto_err = 0;
    logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;
    logic [31:0] mem  [1024];
    logic [31:0] gold [1024];

    always #4 clk = ~clk;

    wt_lock_dcache i_wt_lock_dcache (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .freeze(freeze), .inv_all(inv_all),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] seed(int i);
        return 32'hA500_0000 + 32'(i) * 32'h0001_0003;
    endfunction

    // memory responder: one word per handshake, acknowledge after MEM_LAT falling edges
    initial begin
        int cnt;
        logic busy;
        logic [31:0] held_addr;
        logic held_we;
        cnt = 0; busy = 1'b0; held_addr = '0; held_we = 1'b0;
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (rst_n && mem_req) begin
                if (busy && (mem_addr != held_addr || mem_we != held_we)) proto_err++;
                busy = 1'b1; held_addr = mem_addr; held_we = mem_we;
                if (cnt == MEM_LAT - 1) begin
                    cnt = 0; busy = 1'b0; mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[11:2]] = mem_wdata;
                        wr_count++; last_wr_addr = mem_addr; last_wr_data = mem_wdata;
                    end else begin
                        mem_rdata = mem[mem_addr[11:2]];
                        rd_count++; last_rd_addr = mem_addr;
                    end
                end else begin
                    cnt++;
                end
            end else begin
                if (busy) proto_err++;
                busy = 1'b0; cnt = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        lat = 0;
        forever begin
            #2;
            if (cpu_ready) break;
            @(negedge clk);
            lat++;
            if (lat > 500) break;
        end
        rd = cpu_rdata;
        if (we) gold[addr[11:2]] = wd;
        @(posedge clk);
        #1 cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [31:0] addr, input int exp_reads, input logic [31:0] exp_data,
                          input string req);
        logic [31:0] d;
        int lat, r0;
        r0 = rd_count;
        access(1'b0, addr, 32'h0, d, lat);
        check(rd_count - r0 == exp_reads, req, $sformatf("memory reads for %h", addr),
              32'(rd_count - r0), 32'(exp_reads));
        check(d == exp_data, req, $sformatf("read data %h", addr), d, exp_data);
        if (exp_reads == 0) check(lat == 0, req, "hit latency", 32'(lat), 32'd0);
    endtask

    // {we, addr[11:0], wdata, expected memory reads}
    localparam logic [47:0] VECS [8] = '{
        {1'b0, 12'h020, 32'h0000_0000, 3'd4},   // R1 R3 cold miss refill
        {1'b0, 12'h02C, 32'h0000_0000, 3'd0},   // R2 hit other word of line
        {1'b1, 12'h024, 32'hDEAD_0001, 3'd0},   // R5 R6 store hit
        {1'b0, 12'h024, 32'h0000_0000, 3'd0},   // R6 read updated word
        {1'b1, 12'h324, 32'hBEEF_0004, 3'd0},   // R7 store miss
        {1'b0, 12'h324, 32'h0000_0000, 3'd4},   // R7 read misses, sees stored value
        {1'b0, 12'h128, 32'h0000_0000, 3'd4},   // R3 another tag in the set
        {1'b0, 12'h320, 32'h0000_0000, 3'd0}    // R2 R7 line now present
    };

    initial begin
        logic [31:0] d, old;
        int lat, w0, r0;
        for (int i = 0; i < 1024; i++) begin
            mem[i] = seed(i);
            gold[i] = seed(i);
        end
        rst_n = 1'b0; cache_en = 1'b1; freeze = 1'b0; inv_all = 1'b0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        #2;
        check(cpu_ready == 1'b0, "R1", "cpu_ready after reset", 32'(cpu_ready), 32'd0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);

        for (int k = 0; k < 8; k++) begin
            logic [47:0] v;
            logic [31:0] a;
            int nrd;
            string tag;
            v = VECS[k];
            a = {20'h0, v[46:35]};
            nrd = int'(v[2:0]);
            tag = v[47] ? "R5" : ((nrd == 0) ? "R2" : "R3");
            r0 = rd_count; w0 = wr_count;
            access(v[47], a, v[34:3], d, lat);
            idle(12);
            check(rd_count - r0 == nrd, tag, $sformatf("vector %0d memory reads", k),
                  32'(rd_count - r0), 32'(nrd));
            if (v[47]) begin
                check(lat == 0, "R5", "store latency with empty buffer", 32'(lat), 32'd0);
                check(wr_count == w0 + 1 && last_wr_data == v[34:3], "R5",
                      "write-through data", last_wr_data, v[34:3]);
            end else begin
                check(d == gold[a[11:2]], tag, $sformatf("vector %0d read data", k), d, gold[a[11:2]]);
                if (nrd == 0) check(lat == 0, "R2", "hit latency", 32'(lat), 32'd0);
                else check(last_rd_addr == {a[31:4], 4'hC}, "R3", "last refill address",
                           last_rd_addr, {a[31:4], 4'hC});
            end
        end

        // R5 back-to-back stores: the second waits for the buffer
        w0 = wr_count;
        access(1'b1, 32'h700, 32'h1111_0700, d, lat);
        check(lat == 0, "R5", "first store latency", 32'(lat), 32'd0);
        access(1'b1, 32'h704, 32'h2222_0704, d, lat);
        check(lat > 0, "R5", "second store waits", 32'(lat), 32'd1);
        idle(12);
        check(wr_count == w0 + 2, "R5", "two memory writes", 32'(wr_count - w0), 32'd2);
        check(last_wr_addr == 32'h704, "R5", "write order", last_wr_addr, 32'h704);
        check(mem[32'h700 >> 2] == 32'h1111_0700, "R5", "first store in memory",
              mem[32'h700 >> 2], 32'h1111_0700);

        // R8 read right behind a store to the same address
        access(1'b1, 32'h800, 32'h5555_0800, d, lat);
        rd_chk(32'h800, 4, 32'h5555_0800, "R8");
        idle(12);

        // R4 replacement in set 5
        for (int k = 0; k < 4; k++) rd_chk(32'h050 + 32'(k) * 32'h100, 4, gold[(32'h050 + k * 32'h100) >> 2], "R4");
        rd_chk(32'h050, 0, gold[32'h050 >> 2], "R4");
        rd_chk(32'h450, 4, gold[32'h450 >> 2], "R4");
        rd_chk(32'h050, 0, gold[32'h050 >> 2], "R4");
        rd_chk(32'h150, 4, gold[32'h150 >> 2], "R4");

        // R9 freeze in set 6
        for (int k = 0; k < 4; k++) rd_chk(32'h060 + 32'(k) * 32'h100, 4, gold[(32'h060 + k * 32'h100) >> 2], "R9");
        @(negedge clk); freeze = 1'b1;
        rd_chk(32'h060, 0, gold[32'h060 >> 2], "R9");
        rd_chk(32'h460, 1, gold[32'h460 >> 2], "R9");
        rd_chk(32'h460, 1, gold[32'h460 >> 2], "R9");
        access(1'b1, 32'h260, 32'h6666_0260, d, lat);
        rd_chk(32'h260, 0, 32'h6666_0260, "R9");
        idle(12);
        @(negedge clk); freeze = 1'b0;
        rd_chk(32'h460, 4, gold[32'h460 >> 2], "R9");
        rd_chk(32'h160, 0, gold[32'h160 >> 2], "R9");
        rd_chk(32'h060, 4, gold[32'h060 >> 2], "R9");

        // R10 pass-through leaves the cached copy alone
        @(negedge clk); cache_en = 1'b0;
        old = gold[32'h028 >> 2];
        rd_chk(32'h028, 1, old, "R10");
        access(1'b1, 32'h028, 32'h7777_0028, d, lat);
        idle(12);
        check(mem[32'h028 >> 2] == 32'h7777_0028, "R10", "store reached memory",
              mem[32'h028 >> 2], 32'h7777_0028);
        @(negedge clk); cache_en = 1'b1;
        rd_chk(32'h028, 0, old, "R10");

        // R11 invalidate all
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        rd_chk(32'h028, 4, 32'h7777_0028, "R11");
        rd_chk(32'h350, 4, gold[32'h350 >> 2], "R11");

        // R12 handshake held until acknowledge
        check(proto_err == 0, "R12", "request changed before acknowledge", 32'(proto_err), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule